// File: doc/BRIEF.md
# Converter Operating Mode Sequencer

This block chooses the operating mode of an off-line switching converter controller: power-up charging, regular regulation, low-load pulse bursting, self-recovering fault shutdown and sticky fault shutdown. It never sees an analog voltage. Comparators outside the block turn each threshold on the feedback node, the soft-start/blanking node and the supply node into a synchronized flag. An over-temperature flag and a severe-overcurrent request from the pulse-width path arrive the same way.

The block drives the enables of the supply-side circuits: the high-voltage charging path, the internal bias, the voltage reference and the power-switch pulse path. It also drives a burst indicator, the release of the clamp on the blanking node and a discharge of that node. One soft-start capacitor, charged from its clamp level to a release threshold, times both the entry into burst mode and the overload shutdown. Supply overvoltage and over-temperature pass through a digital persistence filter before they latch the controller off.

Top module: `smps_mode_ctrl`

## Requirements
- R1: After reset the block is in the charging phase. startupEn=1 and ssDischarge=1, and biasEn, refEn, switchEn, burstFlag and clampRelease are 0.
- R2: In the charging phase, vccAboveOn raised for one clock edge moves the block to regulation. From that edge on, startupEn=0, ssDischarge=0 and refEn=biasEn=switchEn=1.
- R3: In regulation, clampRelease follows fbHigh OR fbLow within the same cycle. In every other mode clampRelease is 0.
- R4: In regulation, ssAboveRel together with fbHigh moves the block to self-recovery at the next edge, where refEn, biasEn, switchEn and startupEn are all 0. In that state vccAboveOn has no effect, and vccBelowOff returns the block to the charging phase at the next edge.
- R5: In regulation, ssAboveRel together with fbLow enters burst mode at the next edge. There burstFlag=1, refEn=1, and biasEn=switchEn=0 until the first rise.
- R6: In burst mode, fbBurstOn sets biasEn and switchEn at the next edge, and fbBurstOff clears both at the next edge. With neither flag raised the pair holds its value.
- R7: In burst mode, fbHigh returns the block to regulation at the next edge, with burstFlag=0 and switching enabled.
- R8: In regulation or burst mode, vccBelowOff returns the block to the charging phase at the next edge, with startupEn=1, refEn=0 and ssDischarge=1.
- R9: vccOverVolt counts as a fault only while fbHigh is also 1. A qualified fault held for FILT_CYCLES consecutive edges latches the block off at the following edge, and not before. vccOverVolt with fbHigh=0 has no effect.
- R10: overTemp passes through the same persistence filter. A single-cycle dropout restarts the count from zero.
- R11: In regulation or burst mode, severeOc latches the block off at the next edge, with no filtering.
- R12: In the latched state refEn, biasEn, switchEn and burstFlag are 0. startupEn is cleared on entry, set by vccBelowOff and cleared by vccAboveOn. vccAboveOn never leaves the latched state.
- R13: Only vccBelowReset leaves the latched state. It returns the block to the charging phase at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vccAboveOn | input | 1 | Supply above the turn-on level |
| vccBelowOff | input | 1 | Supply below the turn-off level |
| vccBelowReset | input | 1 | Supply below the latch-clear level |
| vccOverVolt | input | 1 | Supply above the overvoltage level |
| overTemp | input | 1 | Junction over-temperature |
| fbHigh | input | 1 | Feedback above the overload level |
| fbLow | input | 1 | Feedback below the light-load level |
| fbBurstOn | input | 1 | Feedback above the burst restart level |
| fbBurstOff | input | 1 | Feedback at or below the burst pause level |
| ssAboveRel | input | 1 | Blanking node above its release threshold |
| severeOc | input | 1 | Severe overcurrent request from the pulse-width path |
| startupEn | output | 1 | Enable for the high-voltage charging path |
| biasEn | output | 1 | Internal bias enable |
| refEn | output | 1 | Voltage reference enable |
| burstFlag | output | 1 | Burst mode indicator |
| clampRelease | output | 1 | Releases the clamp on the blanking node |
| switchEn | output | 1 | Enables the power-switch pulse path |
| ssDischarge | output | 1 | Discharges the blanking node |

## Verification
The hardest state to reach is the boundary of the persistence filter. The latch must not happen on edge FILT_CYCLES and must happen on the edge after it. A fault that drops out for one cycle must lose everything counted so far. The stimulus holds the qualified overvoltage, and later the over-temperature flag, for an exact number of edges from regulation, samples the enables just before and just after the expected edge, and inserts a one-cycle dropout before the count completes. The latched state's charging hysteresis is exercised the same way: the supply flags are cycled without the reset-level flag, and only then is the latch cleared.

// File: rtl/smps_mode_pkg.sv
`timescale 1ns/1ps
package smps_mode_pkg;

  typedef enum logic [2:0] {
    MD_STARTUP = 3'd0,
    MD_NORMAL  = 3'd1,
    MD_BURST   = 3'd2,
    MD_RESTART = 3'd3,
    MD_LATCHED = 3'd4
  } opMode_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic faultWatch;
    logic burstClear;
    logic latchHold;
  } ctlStrobe_t;

  // State returned from the datapath to the control FSM
  typedef struct packed {
    logic filtTrip;
    logic burstRun;
    logic latchCharge;
  } dpStatus_t;

endpackage

// File: rtl/smps_mode_dp.sv
`timescale 1ns/1ps
module smps_mode_dp
  import smps_mode_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       vccOverVolt,
  input  logic       overTemp,
  input  logic       fbHigh,
  input  logic       fbBurstOn,
  input  logic       fbBurstOff,
  input  logic       vccAboveOn,
  input  logic       vccBelowOff,
  output dpStatus_t  status
);

  localparam int unsigned CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_CYCLES);

  logic [CNT_W-1:0] filtCnt;
  logic             filtIn;
  logic             burstRunQ;
  logic             latchChargeQ;

  // Overvoltage is qualified by overload feedback; temperature is not.
  assign filtIn = strobe.faultWatch & ((vccOverVolt & fbHigh) | overTemp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtCnt <= '0;
    end else if (!filtIn) begin
      filtCnt <= '0;
    end else if (filtCnt != CNT_MAX) begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  // Hysteretic burst run state between the restart and pause levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstRunQ <= 1'b0;
    end else if (strobe.burstClear) begin
      burstRunQ <= 1'b0;
    end else if (fbBurstOn) begin
      burstRunQ <= 1'b1;
    end else if (fbBurstOff) begin
      burstRunQ <= 1'b0;
    end
  end

  // Supply charging hysteresis while latched off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchChargeQ <= 1'b0;
    end else if (!strobe.latchHold) begin
      latchChargeQ <= 1'b0;
    end else if (vccBelowOff) begin
      latchChargeQ <= 1'b1;
    end else if (vccAboveOn) begin
      latchChargeQ <= 1'b0;
    end
  end

  assign status.filtTrip    = (filtCnt == CNT_MAX);
  assign status.burstRun    = burstRunQ;
  assign status.latchCharge = latchChargeQ;

endmodule

// File: rtl/smps_mode_fsm.sv
`timescale 1ns/1ps
module smps_mode_fsm
  import smps_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  status,
  input  logic       vccAboveOn,
  input  logic       vccBelowOff,
  input  logic       vccBelowReset,
  input  logic       fbHigh,
  input  logic       fbLow,
  input  logic       ssAboveRel,
  input  logic       severeOc,
  output ctlStrobe_t strobe,
  output opMode_t    mode,
  output logic       startupEn,
  output logic       biasEn,
  output logic       refEn,
  output logic       burstFlag,
  output logic       clampRelease,
  output logic       switchEn,
  output logic       ssDischarge
);

  opMode_t modeQ;
  opMode_t modeD;
  logic    latchReq;

  assign latchReq = severeOc | status.filtTrip;

  always_comb begin
    modeD = modeQ;
    case (modeQ)
      MD_STARTUP: begin
        if (vccAboveOn) modeD = MD_NORMAL;
      end
      MD_NORMAL: begin
        if (latchReq)                 modeD = MD_LATCHED;
        else if (vccBelowOff)         modeD = MD_STARTUP;
        else if (ssAboveRel && fbHigh) modeD = MD_RESTART;
        else if (ssAboveRel && fbLow)  modeD = MD_BURST;
      end
      MD_BURST: begin
        if (latchReq)         modeD = MD_LATCHED;
        else if (vccBelowOff) modeD = MD_STARTUP;
        else if (fbHigh)      modeD = MD_NORMAL;
      end
      MD_RESTART: begin
        if (vccBelowOff) modeD = MD_STARTUP;
      end
      MD_LATCHED: begin
        if (vccBelowReset) modeD = MD_STARTUP;
      end
      default: modeD = MD_STARTUP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MD_STARTUP;
    else       modeQ <= modeD;
  end

  always_comb begin
    strobe.faultWatch = (modeQ == MD_NORMAL) || (modeQ == MD_BURST);
    strobe.burstClear = (modeQ != MD_BURST);
    strobe.latchHold  = (modeQ == MD_LATCHED);
  end

  always_comb begin
    startupEn    = 1'b0;
    biasEn       = 1'b0;
    refEn        = 1'b0;
    burstFlag    = 1'b0;
    clampRelease = 1'b0;
    switchEn     = 1'b0;
    ssDischarge  = 1'b0;
    case (modeQ)
      MD_STARTUP: begin
        startupEn   = 1'b1;
        ssDischarge = 1'b1;
      end
      MD_NORMAL: begin
        refEn        = 1'b1;
        biasEn       = 1'b1;
        switchEn     = 1'b1;
        clampRelease = fbHigh | fbLow;
      end
      MD_BURST: begin
        refEn     = 1'b1;
        burstFlag = 1'b1;
        biasEn    = status.burstRun;
        switchEn  = status.burstRun;
      end
      MD_LATCHED: begin
        startupEn = status.latchCharge;
      end
      default: ;
    endcase
  end

  assign mode = modeQ;

endmodule

// File: rtl/smps_mode_ctrl.sv
`timescale 1ns/1ps
module smps_mode_ctrl
  import smps_mode_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 1600
) (
  input  logic clk,
  input  logic rstN,
  input  logic vccAboveOn,
  input  logic vccBelowOff,
  input  logic vccBelowReset,
  input  logic vccOverVolt,
  input  logic overTemp,
  input  logic fbHigh,
  input  logic fbLow,
  input  logic fbBurstOn,
  input  logic fbBurstOff,
  input  logic ssAboveRel,
  input  logic severeOc,
  output logic startupEn,
  output logic biasEn,
  output logic refEn,
  output logic burstFlag,
  output logic clampRelease,
  output logic switchEn,
  output logic ssDischarge
);

  ctlStrobe_t strobe;
  dpStatus_t  status;
  opMode_t    mode;

  smps_mode_dp #(.FILT_CYCLES(FILT_CYCLES)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .vccOverVolt (vccOverVolt),
    .overTemp    (overTemp),
    .fbHigh      (fbHigh),
    .fbBurstOn   (fbBurstOn),
    .fbBurstOff  (fbBurstOff),
    .vccAboveOn  (vccAboveOn),
    .vccBelowOff (vccBelowOff),
    .status      (status)
  );

  smps_mode_fsm fsm_i (
    .clk          (clk),
    .rstN         (rstN),
    .status       (status),
    .vccAboveOn   (vccAboveOn),
    .vccBelowOff  (vccBelowOff),
    .vccBelowReset(vccBelowReset),
    .fbHigh       (fbHigh),
    .fbLow        (fbLow),
    .ssAboveRel   (ssAboveRel),
    .severeOc     (severeOc),
    .strobe       (strobe),
    .mode         (mode),
    .startupEn    (startupEn),
    .biasEn       (biasEn),
    .refEn        (refEn),
    .burstFlag    (burstFlag),
    .clampRelease (clampRelease),
    .switchEn     (switchEn),
    .ssDischarge  (ssDischarge)
  );

endmodule

// File: rtl/smps_mode_chk.sv
`timescale 1ns/1ps
module smps_mode_chk
  import smps_mode_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input opMode_t modeIn,
  input logic    vccAboveOn,
  input logic    vccBelowReset,
  input logic    fbHigh,
  input logic    fbLow,
  input logic    severeOc,
  input logic    startupEn,
  input logic    refEn,
  input logic    burstFlag,
  input logic    clampRelease,
  input logic    switchEn
);

  // R2
  startup_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == MD_STARTUP && vccAboveOn) |=> (!startupEn && refEn && switchEn));

  // R3
  clamp_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    clampRelease |-> ((fbHigh || fbLow) && modeIn == MD_NORMAL));

  // R5
  burst_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstFlag |-> (refEn && !startupEn));

  // R7
  burst_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (burstFlag && fbHigh) |=> !burstFlag);

  // R11
  severe_oc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refEn && severeOc) |=> (!refEn && !switchEn && modeIn == MD_LATCHED));

  // R12
  switch_needs_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    switchEn |-> (refEn && !startupEn));

  // R13
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeIn == MD_LATCHED && !vccBelowReset) |=> (modeIn == MD_LATCHED));

endmodule

bind smps_mode_ctrl smps_mode_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .modeIn       (mode),
  .vccAboveOn   (vccAboveOn),
  .vccBelowReset(vccBelowReset),
  .fbHigh       (fbHigh),
  .fbLow        (fbLow),
  .severeOc     (severeOc),
  .startupEn    (startupEn),
  .refEn        (refEn),
  .burstFlag    (burstFlag),
  .clampRelease (clampRelease),
  .switchEn     (switchEn)
);

// File: tb/smps_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module smps_mode_ctrl_tb_top;

  localparam int FILT = 1600;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vccAboveOn = 0, vccBelowOff = 0, vccBelowReset = 0, vccOverVolt = 0;
  logic overTemp = 0, fbHigh = 0, fbLow = 0, fbBurstOn = 0, fbBurstOff = 0;
  logic ssAboveRel = 0, severeOc = 0;
  logic startupEn, biasEn, refEn, burstFlag, clampRelease, switchEn, ssDischarge;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  smps_mode_ctrl #(.FILT_CYCLES(FILT)) dut_i (
    .clk(clk), .rstN(rstN),
    .vccAboveOn(vccAboveOn), .vccBelowOff(vccBelowOff), .vccBelowReset(vccBelowReset),
    .vccOverVolt(vccOverVolt), .overTemp(overTemp), .fbHigh(fbHigh), .fbLow(fbLow),
    .fbBurstOn(fbBurstOn), .fbBurstOff(fbBurstOff), .ssAboveRel(ssAboveRel),
    .severeOc(severeOc),
    .startupEn(startupEn), .biasEn(biasEn), .refEn(refEn), .burstFlag(burstFlag),
    .clampRelease(clampRelease), .switchEn(switchEn), .ssDischarge(ssDischarge)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance n rising edges, then move 1 ns past the last one
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clearIns();
    vccAboveOn = 0; vccBelowOff = 0; vccBelowReset = 0; vccOverVolt = 0;
    overTemp = 0; fbHigh = 0; fbLow = 0; fbBurstOn = 0; fbBurstOff = 0;
    ssAboveRel = 0; severeOc = 0;
  endtask

  task automatic doReset();
    clearIns();
    vccBelowOff = 1;
    rstN = 0;
    step(2);
    rstN = 1;
    step(1);
  endtask

  task automatic bringUp();
    vccBelowOff = 0; vccBelowReset = 0; vccAboveOn = 1;
    step(1);
    vccAboveOn = 0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 startupEn", startupEn, 1);
    chk("R1 ssDischarge", ssDischarge, 1);
    chk("R1 refEn", refEn, 0);
    chk("R1 biasEn", biasEn, 0);
    chk("R1 switchEn", switchEn, 0);
    chk("R1 burstFlag", burstFlag, 0);
    chk("R1 clampRelease", clampRelease, 0);
  endtask

  task automatic t_bringUp();
    doReset();
    bringUp();
    chk("R2 startupEn", startupEn, 0);
    chk("R2 ssDischarge", ssDischarge, 0);
    chk("R2 refEn", refEn, 1);
    chk("R2 biasEn", biasEn, 1);
    chk("R2 switchEn", switchEn, 1);
  endtask

  task automatic t_clamp();
    doReset();
    fbHigh = 1; #1;
    chk("R3 clamp in startup", clampRelease, 0);
    fbHigh = 0;
    bringUp();
    chk("R3 clamp idle", clampRelease, 0);
    fbHigh = 1; #1;
    chk("R3 clamp overload", clampRelease, 1);
    fbHigh = 0; fbLow = 1; #1;
    chk("R3 clamp light load", clampRelease, 1);
    fbLow = 0; #1;
    chk("R3 clamp cleared", clampRelease, 0);
  endtask

  task automatic t_autoRestart();
    doReset();
    bringUp();
    fbHigh = 1;
    step(3);
    chk("R4 still normal while blanking", switchEn, 1);
    ssAboveRel = 1;
    step(1);
    chk("R4 refEn off", refEn, 0);
    chk("R4 switchEn off", switchEn, 0);
    chk("R4 startupEn off", startupEn, 0);
    vccAboveOn = 1;
    step(2);
    chk("R4 onflag ignored", refEn, 0);
    vccAboveOn = 0; vccBelowOff = 1; ssAboveRel = 0; fbHigh = 0;
    step(1);
    chk("R4 back to charging", startupEn, 1);
    chk("R4 discharge", ssDischarge, 1);
    bringUp();
    chk("R4 restart regulates", switchEn, 1);
  endtask

  task automatic t_burst();
    doReset();
    bringUp();
    fbLow = 1; ssAboveRel = 1;
    step(1);
    chk("R5 burstFlag", burstFlag, 1);
    chk("R5 refEn", refEn, 1);
    chk("R5 biasEn", biasEn, 0);
    chk("R5 switchEn", switchEn, 0);
    fbLow = 0; ssAboveRel = 0;
    step(3);
    chk("R6 idle holds off", switchEn, 0);
    fbBurstOn = 1;
    step(1);
    chk("R6 rise biasEn", biasEn, 1);
    chk("R6 rise switchEn", switchEn, 1);
    fbBurstOn = 0;
    step(3);
    chk("R6 hold on", switchEn, 1);
    fbBurstOff = 1;
    step(1);
    chk("R6 pause biasEn", biasEn, 0);
    chk("R6 pause switchEn", switchEn, 0);
    fbBurstOff = 0;
    step(2);
    chk("R6 hold off", biasEn, 0);
    chk("R6 still burst", burstFlag, 1);
    fbHigh = 1;
    step(1);
    chk("R7 burstFlag cleared", burstFlag, 0);
    chk("R7 switching", switchEn, 1);
    chk("R7 bias", biasEn, 1);
    fbHigh = 0;
  endtask

  task automatic t_underVolt();
    doReset();
    bringUp();
    vccBelowOff = 1;
    step(1);
    chk("R8 normal startupEn", startupEn, 1);
    chk("R8 normal refEn", refEn, 0);
    chk("R8 normal discharge", ssDischarge, 1);
    bringUp();
    fbLow = 1; ssAboveRel = 1;
    step(1);
    fbLow = 0; ssAboveRel = 0;
    chk("R8 in burst", burstFlag, 1);
    vccBelowOff = 1;
    step(1);
    chk("R8 burst startupEn", startupEn, 1);
    chk("R8 burst flag off", burstFlag, 0);
  endtask

  task automatic t_overVolt();
    doReset();
    bringUp();
    vccOverVolt = 1;
    step(FILT + 10);
    chk("R9 unqualified ignored", refEn, 1);
    fbHigh = 1;
    step(FILT);
    chk("R9 not yet latched", refEn, 1);
    step(1);
    chk("R9 latched refEn", refEn, 0);
    chk("R9 latched switchEn", switchEn, 0);
    clearIns();
  endtask

  task automatic t_overTemp();
    doReset();
    bringUp();
    overTemp = 1;
    step(FILT - 5);
    overTemp = 0;
    step(1);
    overTemp = 1;
    step(FILT);
    chk("R10 dropout restarted", refEn, 1);
    step(1);
    chk("R10 latched", refEn, 0);
    clearIns();
  endtask

  task automatic t_severe();
    doReset();
    bringUp();
    severeOc = 1;
    step(1);
    severeOc = 0;
    chk("R11 ref off", refEn, 0);
    chk("R11 switch off", switchEn, 0);
    chk("R12 startup off on entry", startupEn, 0);
    chk("R12 bias off", biasEn, 0);
    chk("R12 burst off", burstFlag, 0);
    vccBelowOff = 1;
    step(1);
    chk("R12 charge below off", startupEn, 1);
    chk("R12 ref stays off", refEn, 0);
    vccBelowOff = 0; vccAboveOn = 1;
    step(2);
    chk("R12 charge stops", startupEn, 0);
    chk("R12 no restart", switchEn, 0);
    vccAboveOn = 0; vccBelowOff = 1; vccBelowReset = 1;
    step(1);
    chk("R13 cleared startupEn", startupEn, 1);
    chk("R13 cleared discharge", ssDischarge, 1);
    bringUp();
    chk("R13 regulates again", switchEn, 1);
  endtask

  initial begin
    t_reset();
    t_bringUp();
    t_clamp();
    t_autoRestart();
    t_burst();
    t_underVolt();
    t_overVolt();
    t_overTemp();
    t_severe();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule